// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo PCM bit stream into parallel sample pairs. The stream arrives on three wires: a bit clock, a frame clock that marks the left and right halves of each sample period, and one data line. All three are treated as asynchronous. Each is brought into the system clock domain through a short flop chain. Data and frame level are taken on each detected rising edge of the bit clock.

A 3-bit format code selects one of eight framings. Each framing combines a justification style (right-justified, left-justified, or left-justified with a one-bit delay in the I2S manner) with a word length of 16, 20 or 24 bits. A polarity input decides which level of the frame clock means "left". Words shorter than 24 bits are packed into the top of the 24-bit outputs. Once per frame the block presents a left/right pair together with a single-cycle valid strobe.

The format code is sampled only where a left half begins, so a controller may change it at any time without breaking the frame in progress. After reset the block waits for one transition into a left half before it trusts the framing.

Top module: `pcm_frame_rx`

## Requirements
- R1: In right-justified formats, the word is the last W bits (W = 16, 20 or 24) received before the frame-clock level changes, most significant bit first.
- R2: In left-justified formats, the word is the first W bits (W = 20 or 24) received after the frame-clock level changes, most significant bit first.
- R3: In I2S formats, the word is the W bits that follow one ignored bit after the frame-clock level changes, most significant bit first.
- R4: Format code `fmt_i` decodes as: 0 = 16-bit right, 1 = 20-bit right, 2 = 24-bit right, 3 = 24-bit left, 4 = 16-bit I2S, 5 = 24-bit I2S, 6 = 20-bit I2S, 7 = 20-bit left.
- R5: With `lr_pol_i` = 0, a high frame clock carries the left channel. With `lr_pol_i` = 1, a low frame clock carries the left channel. The left word of a frame is the one that precedes the right word.
- R6: A W-bit word appears in bits [23:24-W] of its output, and bits below that are zero.
- R7: `valid_o` is high for exactly one system clock. It is registered on the third system-clock rising edge after the bit-clock rising edge that completes the right word. `left_o` and `right_o` change only together with `valid_o`. For right-justified formats, that completing edge is the first bit of the next frame.
- R8: `fmt_i` is sampled at the first bit of each left half. A change made at any other time does not affect the frame in progress.
- R9: Synchronous reset clears `left_o`, `right_o` and `valid_o` and samples `fmt_i`. No pair is produced until a frame that begins after the first observed transition into a left half.
- R10: Bits outside the selected word window have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrclk_i | input | 1 | Frame (left/right) clock, asynchronous |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 3 | Format code (see R4) |
| lr_pol_i | input | 1 | Frame-clock polarity select (see R5) |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new pair |

## Verification
Every pair is due three system-clock edges after the bit-clock rise that completes its right word. That rise falls inside the same frame for left-justified and I2S formats, and at the first bit of the following frame for right-justified ones. The bench stamps the cycle of every bit-clock rise it drives and compares that stamp with the cycle at which `valid_o` is seen. It samples on falling clock edges and expects exactly three cycles and a one-cycle pulse. Expected pairs are queued in frame order at send time and compared on each strobe, so the one-frame lag of right-justified pairs needs no special timing. Format changes are driven four bits into each left half, so a mid-frame change would show up as a mismatch on the following pair.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  // Justification style of the serial word inside a half frame.
  typedef enum logic [1:0] {
    JUST_RIGHT  = 2'd0,
    JUST_LEFT   = 2'd1,
    JUST_DELAY1 = 2'd2
  } just_e;

  typedef struct packed {
    just_e      just;
    logic [4:0] len;
  } fmt_t;

  // Combined style/length code, see R4.
  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    unique case (code)
      3'd0:    begin f.just = JUST_RIGHT;  f.len = 5'd16; end
      3'd1:    begin f.just = JUST_RIGHT;  f.len = 5'd20; end
      3'd2:    begin f.just = JUST_RIGHT;  f.len = 5'd24; end
      3'd3:    begin f.just = JUST_LEFT;   f.len = 5'd24; end
      3'd4:    begin f.just = JUST_DELAY1; f.len = 5'd16; end
      3'd5:    begin f.just = JUST_DELAY1; f.len = 5'd24; end
      3'd6:    begin f.just = JUST_DELAY1; f.len = 5'd20; end
      default: begin f.just = JUST_LEFT;   f.len = 5'd20; end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         edge_in,
  input  logic [N-1:0] lvl_in,
  output logic         edge_rise,
  output logic [N-1:0] lvl_out
);

  // Edge input: one extra flop beyond the synchronizer for the edge detect.
  logic [STAGES:0] echain;

  always_ff @(posedge clk) begin
    if (rst) echain <= '0;
    else     echain <= (echain << 1) | {{STAGES{1'b0}}, edge_in};
  end

  assign edge_rise = echain[STAGES-1] & ~echain[STAGES];

  // Level inputs: same depth as the edge path so all three stay aligned.
  for (genvar g = 0; g < N; g++) begin : g_lvl
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= (chain << 1) | {{(STAGES-1){1'b0}}, lvl_in[g]};
    end
    assign lvl_out[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/pcm_rx_slot_tracker.sv
module pcm_rx_slot_tracker #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             lr_lvl,
  input  logic             pol_i,
  input  logic [2:0]       fmt_i,
  output logic             boundary,
  output logic             cur_left,
  output logic             synced,
  output logic [CNT_W-1:0] idx,
  output logic [2:0]       fmt_code
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             seen_q;
  logic             lr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             left_start;

  // Polarity 0: high level is left; polarity 1: low level is left.
  assign cur_left   = lr_lvl ^ pol_i;
  assign boundary   = bit_stb & seen_q & (lr_lvl != lr_q);
  assign left_start = boundary & cur_left;
  // Index of the current bit within its half frame.
  assign idx        = boundary ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      lr_q     <= 1'b0;
      cnt_q    <= '0;
      synced   <= 1'b0;
      fmt_code <= fmt_i;
    end else begin
      if (bit_stb) begin
        seen_q <= 1'b1;
        lr_q   <= lr_lvl;
        if (boundary)              cnt_q <= CNT_ONE;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      end
      if (left_start) begin
        synced   <= 1'b1;
        fmt_code <= fmt_i;
      end
    end
  end

endmodule

// File: rtl/pcm_rx_word_capture.sv
module pcm_rx_word_capture
  import pcm_rx_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             dat_lvl,
  input  logic             boundary,
  input  logic             cur_left,
  input  logic             synced,
  input  logic [CNT_W-1:0] idx,
  input  logic [2:0]       fmt_code,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  fmt_t             fmt;
  logic [OUT_W-1:0] sh_q;
  logic [OUT_W-1:0] sh_next;
  logic [OUT_W-1:0] src;
  logic [OUT_W-1:0] mask;
  logic [OUT_W-1:0] word;
  logic [OUT_W-1:0] left_hold_q;
  logic [CNT_W-1:0] last_idx;
  logic             rj_fire;
  logic             fj_fire;
  logic             fire;
  logic             to_left;

  assign fmt     = decode_fmt(fmt_code);
  assign sh_next = {sh_q[OUT_W-2:0], dat_lvl};

  // Position of the final word bit for the front-justified styles.
  assign last_idx = CNT_W'(fmt.len) + CNT_W'(fmt.just == JUST_DELAY1) - CNT_W'(1);

  // Right-justified: word ends with the bit before the level change,
  // and belongs to the half that just closed.
  assign rj_fire = bit_stb & boundary & synced & (fmt.just == JUST_RIGHT);
  assign fj_fire = bit_stb & synced & (fmt.just != JUST_RIGHT) & (idx == last_idx);
  assign fire    = rj_fire | fj_fire;
  assign to_left = rj_fire ? ~cur_left : cur_left;

  assign src  = rj_fire ? sh_q : sh_next;
  assign mask = {OUT_W{1'b1}} >> (OUT_W - int'(fmt.len));
  assign word = (src & mask) << (OUT_W - int'(fmt.len));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_stb) sh_q <= sh_next;
      if (fire && to_left) left_hold_q <= word;
      if (fire && !to_left) begin
        left_o  <= left_hold_q;
        right_o <= word;
        valid_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx #(
  parameter int OUT_W       = 24,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  input  logic             sdata_i,
  input  logic [2:0]       fmt_i,
  input  logic             lr_pol_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  localparam int N_LVL = 2;

  logic             bit_rise;
  logic [N_LVL-1:0] lvl;
  logic             boundary;
  logic             cur_left;
  logic             synced;
  logic [CNT_W-1:0] idx;
  logic [2:0]       fmt_code;

  pcm_rx_sync #(
    .STAGES (SYNC_STAGES),
    .N      (N_LVL)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .edge_in   (bclk_i),
    .lvl_in    ({sdata_i, lrclk_i}),
    .edge_rise (bit_rise),
    .lvl_out   (lvl)
  );

  pcm_rx_slot_tracker #(
    .CNT_W (CNT_W)
  ) u_track (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_rise),
    .lr_lvl   (lvl[0]),
    .pol_i    (lr_pol_i),
    .fmt_i    (fmt_i),
    .boundary (boundary),
    .cur_left (cur_left),
    .synced   (synced),
    .idx      (idx),
    .fmt_code (fmt_code)
  );

  pcm_rx_word_capture #(
    .OUT_W (OUT_W),
    .CNT_W (CNT_W)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_rise),
    .dat_lvl  (lvl[1]),
    .boundary (boundary),
    .cur_left (cur_left),
    .synced   (synced),
    .idx      (idx),
    .fmt_code (fmt_code),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

endmodule

// File: rtl/pcm_frame_rx_chk.sv
module pcm_frame_rx_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_rise,
  input logic             boundary,
  input logic             cur_left,
  input logic [2:0]       fmt_code,
  input logic [OUT_W-1:0] left_o,
  input logic [OUT_W-1:0] right_o,
  input logic             valid_o
);

  logic rst_d = 1'b0;

  always @(posedge clk) rst_d <= rst;

  // R9: the cycle after a reset edge shows cleared outputs.
  always @(posedge clk) begin
    if (rst_d) begin
      a_r9_reset_clear: assert (!valid_o && left_o == '0 && right_o == '0)
        else $error("outputs not cleared by reset");
    end
  end

  // R7: strobe lasts one cycle.
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7: outputs move only with the strobe.
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R7: a pair is always launched by a detected bit-clock rise.
  a_r7_after_bit_edge: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(bit_rise));

  // R8: the active format moves only where a left half begins.
  a_r8_fmt_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !(boundary && cur_left) |=> $stable(fmt_code));

endmodule

bind pcm_frame_rx pcm_frame_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_rise (bit_rise),
  .boundary (boundary),
  .cur_left (cur_left),
  .fmt_code (fmt_code),
  .left_o   (left_o),
  .right_o  (right_o),
  .valid_o  (valid_o)
);

// File: tb/pcm_frame_rx_bench.sv
module pcm_frame_rx_bench;

  localparam int HALF = 32;

  logic        clk   = 1'b0;
  logic        rst   = 1'b1;
  logic        bclk  = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic        pol   = 1'b0;
  logic [2:0]  fmt   = 3'd0;
  logic [23:0] left_w;
  logic [23:0] right_w;
  logic        valid;

  pcm_frame_rx u_pcm_frame_rx (
    .clk      (clk),
    .rst      (rst),
    .bclk_i   (bclk),
    .lrclk_i  (lrclk),
    .sdata_i  (sdata),
    .fmt_i    (fmt),
    .lr_pol_i (pol),
    .left_o   (left_w),
    .right_o  (right_w),
    .valid_o  (valid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rise_cyc = 0;
  int n_valid = 0;
  int wr_i = 0;
  int rd_i = 0;
  logic valid_d = 1'b0;
  int unsigned seed = 32'h1234_5678;

  logic [23:0] exp_l [0:127];
  logic [23:0] exp_r [0:127];
  logic [2:0]  exp_f [0:127];

  always @(posedge clk) cyc <= cyc + 1;

  // Word length per format code (R4).
  function automatic int w_of(input logic [2:0] f);
    case (f)
      3'd0, 3'd4:       return 16;
      3'd1, 3'd6, 3'd7: return 20;
      default:          return 24;
    endcase
  endfunction

  // 0 right-justified, 1 left-justified, 2 I2S (R4).
  function automatic int j_of(input logic [2:0] f);
    case (f)
      3'd0, 3'd1, 3'd2: return 0;
      3'd3, 3'd7:       return 1;
      default:          return 2;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (j_of(f))
      0:       return "R1";
      1:       return "R2";
      default: return "R3";
    endcase
  endfunction

  // R6: left-aligned, zero-filled expectation.
  function automatic logic [23:0] aligned(input logic [2:0] f, input logic [23:0] v);
    int w;
    logic [23:0] m;
    w = w_of(f);
    m = 24'hFFFFFF >> (24 - w);
    return (v & m) << (24 - w);
  endfunction

  // Bit for slot i of a half frame; idle slots carry ones (R10).
  function automatic logic slot_bit(input logic [2:0] f, input logic [23:0] v, input int i);
    int w;
    w = w_of(f);
    case (j_of(f))
      0: if (i >= HALF - w) return v[w - 1 - (i - (HALF - w))];
      1: if (i < w) return v[w - 1 - i];
      default: if (i >= 1 && i <= w) return v[w - i];
    endcase
    return 1'b1;
  endfunction

  function automatic logic [23:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:8];
  endfunction

  // Pair monitor (R1-R7, R9, R10).
  always @(negedge clk) begin
    if (!rst && valid) begin
      n_valid++;
      checks++;
      if (cyc - rise_cyc != 3) begin
        errors++;
        $display("FAIL R7 strobe latency act %0d exp 3", cyc - rise_cyc);
      end
      checks++;
      if (valid_d) begin
        errors++;
        $display("FAIL R7 strobe width act 2 exp 1");
      end
      checks++;
      if (rd_i >= wr_i) begin
        errors++;
        $display("FAIL R9 unexpected pair act %h/%h exp none", left_w, right_w);
      end else begin
        if (left_w !== exp_l[rd_i] || right_w !== exp_r[rd_i]) begin
          errors++;
          $display("FAIL %s R4 R5 R6 R10 fmt %0d pol %0d act %h/%h exp %h/%h",
                   tag_of(exp_f[rd_i]), exp_f[rd_i], pol,
                   left_w, right_w, exp_l[rd_i], exp_r[rd_i]);
        end
        rd_i++;
      end
    end
    valid_d = valid;
  end

  task automatic send_bit(input logic lr, input logic d);
    lrclk = lr;
    sdata = d;
    bclk  = 1'b0;
    repeat (3) @(negedge clk);
    bclk     = 1'b1;
    rise_cyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  // next_f is applied four bits into the left half (R8).
  task automatic send_half(input logic lr, input logic [2:0] f, input logic [23:0] v,
                           input logic [2:0] next_f);
    for (int i = 0; i < HALF; i++) begin
      send_bit(lr, slot_bit(f, v, i));
      if (i == 3) fmt = next_f;
    end
  endtask

  task automatic send_frame(input logic [2:0] f, input logic [23:0] l, input logic [23:0] r,
                            input logic [2:0] next_f, input bit push);
    if (push) begin
      exp_l[wr_i] = aligned(f, l);
      exp_r[wr_i] = aligned(f, r);
      exp_f[wr_i] = f;
      wr_i++;
    end
    send_half(~pol, f, l, next_f);
    send_half(pol, f, r, next_f);
  endtask

  task automatic do_reset(input logic [2:0] f0);
    @(negedge clk);
    rst  = 1'b1;
    fmt  = f0;
    bclk = 1'b0;
    repeat (4) @(negedge clk);
    rst     = 1'b0;
    wr_i    = 0;
    rd_i    = 0;
    n_valid = 0;
    @(negedge clk);
    checks++;
    if (valid !== 1'b0 || left_w !== 24'd0 || right_w !== 24'd0) begin
      errors++;
      $display("FAIL R9 reset state act %b %h %h exp 0 0 0", valid, left_w, right_w);
    end
  endtask

  task automatic run_cfg(input logic p, input logic [2:0] base, input bit mixed, input int n);
    logic [2:0] fcur;
    logic [2:0] fnext;
    pol = p;
    do_reset(base);
    send_frame(base, nxt(), nxt(), base, 1'b0);
    checks++;
    if (n_valid != 0) begin
      errors++;
      $display("FAIL R9 pair before first full frame act %0d exp 0", n_valid);
    end
    for (int k = 0; k < n; k++) begin
      fcur  = mixed ? base + 3'(k) : base;
      fnext = (k == n - 1) ? 3'd3 : (mixed ? base + 3'(k + 1) : base);
      send_frame(fcur, nxt(), nxt(), fnext, 1'b1);
    end
    send_frame(3'd3, nxt(), nxt(), 3'd3, 1'b1);
    repeat (10) @(negedge clk);
    checks++;
    if (rd_i != wr_i) begin
      errors++;
      $display("FAIL R7 pairs delivered act %0d exp %0d", rd_i, wr_i);
    end
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      for (int f = 0; f < 8; f++) begin
        run_cfg(p[0], 3'(f), 1'b0, 3);
      end
    end
    run_cfg(1'b0, 3'd0, 1'b1, 8);
    run_cfg(1'b1, 3'd5, 1'b1, 8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL R7 watchdog expired act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule